// File: doc/BRIEF.md
# Headphone Playback Power Sequencer

This block sits on the host side of a stereo audio codec. It turns a single start command into the ordered list of register writes that brings up the digital-to-analog path into the headphone amplifier, and a single stop command into the matching tear-down list. Every write leaves through a plain valid/ready register-write port carrying an address and a data byte. A downstream serial-bus master, which is not part of this block, moves each write to the codec.

The headphone amplifier's common voltage ramps slowly through an external capacitor, with a time constant of up to 250 ms. If the amplifier loses power while that voltage is still high, the output pops. The sequencer therefore holds a timed wait after it sets the ramp-up control bit, and another after it clears that bit, and it will not power the amplifier down until the second wait has run out. Waits are counted in ticks of a one-cycle millisecond strobe, so they do not depend on the system clock rate.

While a sequence runs the block reports busy and ignores both commands. Once bring-up is complete it reports playing, and a stop command is accepted only in that state.

Top module: `hp_playback_seq`

## Requirements
- R1: After reset, `busy_o`, `playing_o` and `wr_valid_o` are all 0.
- R2: A `start_i` pulse in the idle state raises `busy_o` and `wr_valid_o` on the next cycle. The block then issues these writes as (address, data) in hex, one after another: (05,27) (0F,09) (0E,19) (09,91) (0C,91) (0A,VOL) (0D,VOL) (00,64) (01,39) (01,79). VOL is the output-volume parameter, 28 by default.
- R3: Each volume setting is sent as two consecutive writes with the left-channel address first: 09 before 0C, and 0A before 0D. The input-volume data is 91 (0 dB).
- R4: Once `wr_valid_o` is raised, it stays high with `wr_addr_o` and `wr_data_o` unchanged until a cycle in which `wr_ready_i` is 1. A write is complete in that cycle. The next write, if there is one, is presented on the following cycle.
- R5: After the (01,79) write completes, no write is issued. `playing_o` rises in the cycle after the RAMP_MS-th `ms_tick_i` pulse counted from the cycle after that completion, and `busy_o` falls at the same time.
- R6: A `stop_i` pulse while playing drops `playing_o`, raises `busy_o` and issues (01,39) on the next cycle. The writes (01,09) (00,40) (0E,11) (0F,08) follow, and `busy_o` falls in the cycle after the last one completes.
- R7: The (01,09) write is not presented until RAMP_MS ticks have been counted after the (01,39) shutdown write completes. It appears in the cycle after the final tick.
- R8: `start_i` and `stop_i` have no effect while `busy_o` is 1. `stop_i` has no effect while idle, and `start_i` has no effect while playing.
- R9: `busy_o` and `playing_o` are never both 1. No write is presented while `playing_o` is 1 or while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-playback command, one-cycle pulse |
| stop_i | input | 1 | Stop-playback command, one-cycle pulse |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| wr_valid_o | output | 1 | Register write presented |
| wr_ready_i | input | 1 | Downstream accepts the presented write |
| wr_addr_o | output | ADDR_W | Codec register address |
| wr_data_o | output | DATA_W | Codec register data |
| busy_o | output | 1 | A bring-up or tear-down sequence is running |
| playing_o | output | 1 | Playback path fully up |

## Verification
If the step index is wrong, the very next write shows the wrong address or data, or the sequence is one write short or long. That is visible at the write port on the first handshake after the fault. If the state or the timer is wrong, `playing_o` rises early or late, or (01,09) appears before or after the cycle that follows the RAMP_MS-th tick, so the error is exposed within one ramp window. If the hold logic is wrong, the address, data or valid changes during a stall, which shows in the same cycle while `wr_ready_i` is low.

// File: rtl/hps_pkg.sv
`timescale 1ns/1ps
package hps_pkg;

   typedef enum logic [2:0] {
      S_IDLE    = 3'd0,
      S_UP_WR   = 3'd1,
      S_UP_WAIT = 3'd2,
      S_PLAY    = 3'd3,
      S_DN_MUTE = 3'd4,
      S_DN_WAIT = 3'd5,
      S_DN_WR   = 3'd6
   } seq_state_t;

   localparam int CODEC_W = 8;

   typedef struct packed {
      logic [CODEC_W-1:0] addr;
      logic [CODEC_W-1:0] data;
   } codec_wr_t;

   function automatic codec_wr_t mk_wr(input logic [CODEC_W-1:0] a,
                                       input logic [CODEC_W-1:0] d);
      codec_wr_t w;
      w.addr = a;
      w.data = d;
      return w;
   endfunction

   // power-register values used on both sides of the sequence
   localparam logic [CODEC_W-1:0] IN_VOL_0DB  = 8'h91;
   localparam logic [CODEC_W-1:0] HP_RAMP_UP  = 8'h79;
   localparam logic [CODEC_W-1:0] HP_ON_QUIET = 8'h39;
   localparam logic [CODEC_W-1:0] HP_OFF      = 8'h09;

endpackage

// File: rtl/hps_step_rom.sv
`timescale 1ns/1ps
module hps_step_rom
   import hps_pkg::*;
#(
   parameter bit                 DUAL_VOL = 1'b1,
   parameter logic [CODEC_W-1:0] OUT_VOL  = 8'h28,
   parameter int                 IDX_W    = 4
) (
   input  logic             dn_i,
   input  logic [IDX_W-1:0] idx_i,
   output codec_wr_t        wr_o,
   output logic             last_o
);

   codec_wr_t up_wr, dn_wr;
   logic      up_last, dn_last;

   generate
      if (DUAL_VOL) begin : g_dual
         always_comb begin
            up_last = 1'b0;
            unique case (idx_i)
               IDX_W'(0): up_wr = mk_wr(8'h05, 8'h27);
               IDX_W'(1): up_wr = mk_wr(8'h0F, 8'h09);
               IDX_W'(2): up_wr = mk_wr(8'h0E, 8'h19);
               IDX_W'(3): up_wr = mk_wr(8'h09, IN_VOL_0DB);
               IDX_W'(4): up_wr = mk_wr(8'h0C, IN_VOL_0DB);
               IDX_W'(5): up_wr = mk_wr(8'h0A, OUT_VOL);
               IDX_W'(6): up_wr = mk_wr(8'h0D, OUT_VOL);
               IDX_W'(7): up_wr = mk_wr(8'h00, 8'h64);
               IDX_W'(8): up_wr = mk_wr(8'h01, HP_ON_QUIET);
               default: begin
                  up_wr   = mk_wr(8'h01, HP_RAMP_UP);
                  up_last = 1'b1;
               end
            endcase
         end
      end else begin : g_linked
         always_comb begin
            up_last = 1'b0;
            unique case (idx_i)
               IDX_W'(0): up_wr = mk_wr(8'h05, 8'h27);
               IDX_W'(1): up_wr = mk_wr(8'h0F, 8'h09);
               IDX_W'(2): up_wr = mk_wr(8'h0E, 8'h19);
               IDX_W'(3): up_wr = mk_wr(8'h09, IN_VOL_0DB);
               IDX_W'(4): up_wr = mk_wr(8'h0A, OUT_VOL);
               IDX_W'(5): up_wr = mk_wr(8'h00, 8'h64);
               IDX_W'(6): up_wr = mk_wr(8'h01, HP_ON_QUIET);
               default: begin
                  up_wr   = mk_wr(8'h01, HP_RAMP_UP);
                  up_last = 1'b1;
               end
            endcase
         end
      end
   endgenerate

   always_comb begin
      dn_last = 1'b0;
      unique case (idx_i)
         IDX_W'(0): dn_wr = mk_wr(8'h01, HP_ON_QUIET);
         IDX_W'(1): dn_wr = mk_wr(8'h01, HP_OFF);
         IDX_W'(2): dn_wr = mk_wr(8'h00, 8'h40);
         IDX_W'(3): dn_wr = mk_wr(8'h0E, 8'h11);
         default: begin
            dn_wr   = mk_wr(8'h0F, 8'h08);
            dn_last = 1'b1;
         end
      endcase
   end

   assign wr_o   = dn_i ? dn_wr   : up_wr;
   assign last_o = dn_i ? dn_last : up_last;

endmodule

// File: rtl/hps_ramp_timer.sv
`timescale 1ns/1ps
module hps_ramp_timer #(
   parameter int RAMP_MS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic run_i,
   input  logic tick_i,
   output logic expire_o
);

   localparam int CNT_W = $clog2(RAMP_MS + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(RAMP_MS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (run_i && tick_i)
         cnt_q <= cnt_q + CNT_W'(1);
   end

   assign expire_o = run_i && tick_i && (cnt_q == LAST_CNT);

endmodule

// File: rtl/hps_wr_port.sv
`timescale 1ns/1ps
module hps_wr_port #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] ld_addr_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic              ready_i,
   output logic              valid_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   output logic              done_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         addr_o  <= '0;
         data_o  <= '0;
      end else if (load_i) begin
         valid_o <= 1'b1;
         addr_o  <= ld_addr_i;
         data_o  <= ld_data_i;
      end else if (valid_o && ready_i) begin
         valid_o <= 1'b0;
      end
   end

   assign done_o = valid_o && ready_i;

endmodule

// File: rtl/hp_playback_seq.sv
`timescale 1ns/1ps
module hp_playback_seq
   import hps_pkg::*;
#(
   parameter int                 ADDR_W   = 8,
   parameter int                 DATA_W   = 8,
   parameter int                 RAMP_MS  = 500,
   parameter bit                 DUAL_VOL = 1'b1,
   parameter logic [CODEC_W-1:0] OUT_VOL  = 8'h28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              ms_tick_i,
   output logic              wr_valid_o,
   input  logic              wr_ready_i,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              busy_o,
   output logic              playing_o
);

   localparam int UP_LEN = DUAL_VOL ? 10 : 8;
   localparam int DN_LEN = 5;
   localparam int MAX_LEN = (UP_LEN > DN_LEN) ? UP_LEN : DN_LEN;
   localparam int IDX_W  = $clog2(MAX_LEN);

   generate
      if (ADDR_W < CODEC_W) begin : g_bad_addr
         $error("ADDR_W must be at least 8");
      end
      if (DATA_W < CODEC_W) begin : g_bad_data
         $error("DATA_W must be at least 8");
      end
      if (RAMP_MS < 1) begin : g_bad_ramp
         $error("RAMP_MS must be at least 1");
      end
   endgenerate

   seq_state_t       state_q, state_d;
   logic [IDX_W-1:0] idx_q, ld_idx;
   logic             ld_dn, load, last_q;
   logic             tmr_clr, tmr_run, tmr_expire;
   logic             wr_done;
   codec_wr_t        rom_wr;
   logic             rom_last;

   hps_step_rom #(
      .DUAL_VOL (DUAL_VOL),
      .OUT_VOL  (OUT_VOL),
      .IDX_W    (IDX_W)
   ) u_rom (
      .dn_i   (ld_dn),
      .idx_i  (ld_idx),
      .wr_o   (rom_wr),
      .last_o (rom_last)
   );

   hps_wr_port #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .ld_addr_i (ADDR_W'(rom_wr.addr)),
      .ld_data_i (DATA_W'(rom_wr.data)),
      .ready_i   (wr_ready_i),
      .valid_o   (wr_valid_o),
      .addr_o    (wr_addr_o),
      .data_o    (wr_data_o),
      .done_o    (wr_done)
   );

   assign tmr_run = (state_q == S_UP_WAIT) || (state_q == S_DN_WAIT);

   hps_ramp_timer #(
      .RAMP_MS (RAMP_MS)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (tmr_clr),
      .run_i    (tmr_run),
      .tick_i   (ms_tick_i),
      .expire_o (tmr_expire)
   );

   always_comb begin
      state_d = state_q;
      load    = 1'b0;
      ld_dn   = 1'b0;
      ld_idx  = idx_q;
      tmr_clr = 1'b0;
      unique case (state_q)
         S_IDLE: begin
            if (start_i) begin
               load    = 1'b1;
               ld_idx  = '0;
               state_d = S_UP_WR;
            end
         end
         S_UP_WR: begin
            if (wr_done) begin
               if (last_q) begin
                  tmr_clr = 1'b1;
                  state_d = S_UP_WAIT;
               end else begin
                  load   = 1'b1;
                  ld_idx = idx_q + IDX_W'(1);
               end
            end
         end
         S_UP_WAIT: begin
            if (tmr_expire) state_d = S_PLAY;
         end
         S_PLAY: begin
            if (stop_i) begin
               load    = 1'b1;
               ld_dn   = 1'b1;
               ld_idx  = '0;
               state_d = S_DN_MUTE;
            end
         end
         S_DN_MUTE: begin
            ld_dn = 1'b1;
            if (wr_done) begin
               tmr_clr = 1'b1;
               state_d = S_DN_WAIT;
            end
         end
         S_DN_WAIT: begin
            ld_dn = 1'b1;
            if (tmr_expire) begin
               load    = 1'b1;
               ld_idx  = IDX_W'(1);
               state_d = S_DN_WR;
            end
         end
         S_DN_WR: begin
            ld_dn = 1'b1;
            if (wr_done) begin
               if (last_q) begin
                  state_d = S_IDLE;
               end else begin
                  load   = 1'b1;
                  ld_idx = idx_q + IDX_W'(1);
               end
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         last_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (load) begin
            idx_q  <= ld_idx;
            last_q <= rom_last;
         end
      end
   end

   assign busy_o    = (state_q != S_IDLE) && (state_q != S_PLAY);
   assign playing_o = (state_q == S_PLAY);

endmodule

// File: rtl/hps_checker.sv
`timescale 1ns/1ps
module hps_checker #(
   parameter int ADDR_W  = 8,
   parameter int DATA_W  = 8,
   parameter int RAMP_MS = 500
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              ms_tick_i,
   input logic              wr_valid_o,
   input logic              wr_ready_i,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [DATA_W-1:0] wr_data_o,
   input logic              busy_o,
   input logic              playing_o
);

   localparam int CW = $clog2(RAMP_MS + 2);

   logic hs, hs_quiet, hs_rise, hs_off;
   logic [CW-1:0] since_rise, since_quiet;

   assign hs       = wr_valid_o && wr_ready_i;
   assign hs_quiet = hs && (wr_addr_o == ADDR_W'(8'h01)) && (wr_data_o == DATA_W'(8'h39));
   assign hs_rise  = hs && (wr_addr_o == ADDR_W'(8'h01)) && (wr_data_o == DATA_W'(8'h79));
   assign hs_off   = hs && (wr_addr_o == ADDR_W'(8'h01)) && (wr_data_o == DATA_W'(8'h09));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rise  <= '0;
         since_quiet <= '0;
      end else begin
         if (hs_rise) since_rise <= '0;
         else if (ms_tick_i && since_rise < CW'(RAMP_MS)) since_rise <= since_rise + CW'(1);
         if (hs_quiet) since_quiet <= '0;
         else if (ms_tick_i && since_quiet < CW'(RAMP_MS)) since_quiet <= since_quiet + CW'(1);
      end
   end

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

   assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && playing_o));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (playing_o || !busy_o) |-> !wr_valid_o);

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !playing_o && start_i) |=> (busy_o && wr_valid_o));

   assert_ramp_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(playing_o) |-> (since_rise >= CW'(RAMP_MS)));

   assert_ramp_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hs_off |-> (since_quiet >= CW'(RAMP_MS)));

endmodule

bind hp_playback_seq hps_checker #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .RAMP_MS (RAMP_MS)
) u_hps_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .ms_tick_i  (ms_tick_i),
   .wr_valid_o (wr_valid_o),
   .wr_ready_i (wr_ready_i),
   .wr_addr_o  (wr_addr_o),
   .wr_data_o  (wr_data_o),
   .busy_o     (busy_o),
   .playing_o  (playing_o)
);

// File: tb/tb_hp_playback_seq.sv
`timescale 1ns/1ps
module tb_hp_playback_seq;

   localparam int RAMP = 500;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, stop = 1'b0, tick = 1'b0, ready = 1'b0;
   logic wr_valid, busy, playing;
   logic [7:0] wr_addr, wr_data;

   always #2.5 clk = ~clk;

   hp_playback_seq dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop),
      .ms_tick_i(tick), .wr_valid_o(wr_valid), .wr_ready_i(ready),
      .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .busy_o(busy), .playing_o(playing)
   );

   int checks = 0, fails = 0, cycles = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference: phases 0 idle,1 bring-up writes,2 rise wait,3 playing,
   // 4 quiet write,5 fall wait,6 shutdown writes
   int          ph = 0, cnt = 0;
   logic        m_valid = 1'b0;
   logic [15:0] q[$];
   logic [15:0] log_q[$];

   function automatic void fill_up();
      q = '{16'h0527, 16'h0F09, 16'h0E19, 16'h0991, 16'h0C91,
            16'h0A28, 16'h0D28, 16'h0064, 16'h0139, 16'h0179};
   endfunction

   function automatic void fill_dn();
      q = '{16'h0139, 16'h0109, 16'h0040, 16'h0E11, 16'h0F08};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_valid = 1'b0; q.delete();
      end else begin
         case (ph)
            0: if (start) begin fill_up(); m_valid = 1'b1; ph = 1; end
            1: if (m_valid && ready) begin
                  void'(q.pop_front());
                  if (q.size() == 0) begin m_valid = 1'b0; ph = 2; cnt = 0; end
               end
            2: if (tick) begin cnt++; if (cnt == RAMP) ph = 3; end
            3: if (stop) begin fill_dn(); m_valid = 1'b1; ph = 4; end
            4: if (m_valid && ready) begin
                  void'(q.pop_front()); m_valid = 1'b0; ph = 5; cnt = 0;
               end
            5: if (tick) begin cnt++; if (cnt == RAMP) begin ph = 6; m_valid = 1'b1; end end
            6: if (m_valid && ready) begin
                  void'(q.pop_front());
                  if (q.size() == 0) begin m_valid = 1'b0; ph = 0; end
               end
            default: ph = 0;
         endcase
      end
   end

   int   tick_div = 4, tick_c = 0, ready_mode = 0;
   logic [7:0] lfsr = 8'hA5;

   task automatic step(input logic s, input logic p);
      string dtag, vtag;
      @(negedge clk);
      cycles++;
      if (rst_n) begin
         dtag = (ph <= 1) ? "R2" : (ph == 2 || ph == 3) ? "R5" : (ph == 5) ? "R7" : "R6";
         vtag = (ph == 1 || ph == 4 || ph == 6) ? "R4" : dtag;
         chk({"R9 busy ", dtag}, busy, (ph != 0 && ph != 3));
         chk({"playing ", dtag}, playing, (ph == 3));
         chk({"valid ", vtag}, wr_valid, m_valid);
         if (m_valid) begin
            chk({"addr ", vtag}, wr_addr, q[0][15:8]);
            chk({"data ", vtag}, wr_data, q[0][7:0]);
         end
      end
      start = s;
      stop  = p;
      tick  = (tick_c % tick_div) == 0;
      tick_c++;
      lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
      if (wr_valid && ready) log_q.push_back({wr_addr, wr_data});
   endtask

   task automatic run_until(input int phase);
      int n = 0;
      while (ph != phase && n < 20000) begin step(0, 0); n++; end
   endtask

   task automatic check_pairs();
      int i9 = -1, ia = -1;
      foreach (log_q[i]) begin
         if (log_q[i] == 16'h0991 && i9 < 0) i9 = i;
         if (log_q[i] == 16'h0A28 && ia < 0) ia = i;
      end
      chk("R3 left input volume present", (i9 >= 0), 1);
      chk("R3 left output volume present", (ia >= 0), 1);
      if (i9 >= 0 && i9 + 1 < log_q.size()) chk("R3 right input follows", log_q[i9+1], 16'h0C91);
      if (ia >= 0 && ia + 1 < log_q.size()) chk("R3 right output follows", log_q[ia+1], 16'h0D28);
      chk("R6 full write count", log_q.size(), 15);
      if (log_q.size() == 15) begin
         chk("R6 first shutdown write", log_q[10], 16'h0139);
         chk("R6 headphone off", log_q[11], 16'h0109);
         chk("R6 last shutdown write", log_q[14], 16'h0F08);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (3) step(0, 0);
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 playing", playing, 0);
      chk("R1 valid", wr_valid, 0);
      rst_n = 1'b1;

      // run A: ready always high, tick every 4 cycles
      step(0, 1);
      step(0, 0);
      chk("R8 stop in idle busy", busy, 0);
      chk("R8 stop in idle valid", wr_valid, 0);
      step(1, 0);
      step(0, 0);
      chk("R2 busy after start", busy, 1);
      step(1, 1);
      step(0, 0);
      chk("R8 commands while busy", wr_addr, 8'h0E);
      run_until(3);
      step(1, 0);
      step(0, 0);
      chk("R8 start while playing", playing, 1);
      chk("R8 start while playing busy", busy, 0);
      step(0, 1);
      run_until(5);
      step(1, 1);
      step(0, 0);
      chk("R8 commands in fall wait", wr_valid, 0);
      run_until(0);
      step(0, 0);
      check_pairs();

      // run B: stalling ready, tick every 3 cycles
      log_q.delete();
      ready_mode = 1;
      tick_div   = 3;
      step(1, 0);
      run_until(3);
      step(0, 1);
      run_until(0);
      step(0, 0);
      step(0, 0);
      check_pairs();
      chk("R9 idle at end", busy, 0);

      finished = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule